// File: doc/BRIEF.md
# Trigger Pipeline Buffer Controller

This block keeps the addresses of a circular sample pipeline that takes one new sample per sampling clock. A write column counter steps once per clock around a ring of columns. When a trigger arrives, the block works out which column was written a programmed number of clocks earlier and places that column number in a short derandomising queue. A readout engine takes the oldest queued column, reads the stored sample from it, and signals completion, which removes the entry.

The ring is sized as the largest latency plus the queue depth plus a small guard. A column that waits in the queue is therefore not overwritten while the readout keeps pace with the trigger rate. The latency setting is taken in only while nothing is queued, so every queued entry uses the same latency. A trigger that finds the queue full is lost and sets a flag that stays set until reset.

Top module: `trig_pipe_ctrl`

## Requirements
- R1: After reset, `wr_col_o` is 0, `rd_valid_o` is 0 and `ovf_o` is 0.
- R2: `wr_col_o` rises by one on every clock edge and goes from RING-1 back to 0. RING = LAT_MAX + QDEPTH + GUARD, which is 180 with the default values.
- R3: A trigger sampled on a clock edge queues the column (W - L) mod RING. W is the value `wr_col_o` holds before that edge and L is the latency in effect.
- R4: The queue is first-in first-out. `rd_valid_o` is 1 exactly when the queue holds at least one entry, and `rd_col_o` then shows the oldest entry. `rd_done_i` high on an edge removes that entry. `rd_done_i` has no effect while the queue is empty.
- R5: Triggers on consecutive clock edges each add their own entry. Because `wr_col_o` advances between them, these entries are consecutive columns.
- R6: The queue holds QDEPTH entries (16 by default). A trigger that arrives while it is full is dropped, and the queue contents stay as they were. Such a trigger sets `ovf_o`, which then stays at 1 until reset.
- R7: The latency in effect is loaded from `lat_cfg_i` only on edges where the queue was empty before the edge. A change made while entries are queued takes effect once the queue has drained.
- R8: A `lat_cfg_i` value above LAT_MAX (160) is used as LAT_MAX.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| trig_i | input | 1 | Trigger, one entry per high cycle |
| lat_cfg_i | input | LATW (8) | Requested latency in sampling clocks |
| rd_done_i | input | 1 | Readout engine finished the oldest entry |
| wr_col_o | output | COLW (8) | Column written this clock |
| rd_col_o | output | COLW (8) | Oldest queued column |
| rd_valid_o | output | 1 | Queue holds at least one column |
| ovf_o | output | 1 | Sticky trigger-lost flag |

## Verification
Every cycle, the assertions check the following. The write column stays inside the ring and wraps to zero. The queue fill never exceeds its depth. An accepted trigger always leaves an entry valid. A trigger into a full queue sets the overflow flag and leaves the queue full. The flag never clears. The latency register holds still while entries are queued. The exact column arithmetic for every latency value, including the clamped values above the maximum, can only be shown by the bench's scenarios. The same holds for first-in first-out order across a full queue, the deferred latency change, and the behaviour of completions with nothing queued.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
   function automatic int ring_size(input int lat_max, input int qdepth, input int guard);
      return lat_max + qdepth + guard;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/tpc_wr_ring.sv
module tpc_wr_ring #(
   parameter int RING = 180,
   parameter int COLW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [COLW-1:0] col_o
);
   localparam logic [COLW-1:0] LAST = COLW'(RING - 1);

   logic [COLW-1:0] col_q;

   generate
      if (tpc_pkg::is_pow2(RING) && (RING == (1 << COLW))) begin : g_natural
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) col_q <= '0;
            else        col_q <= col_q + 1'b1;
         end
      end else begin : g_compare
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             col_q <= '0;
            else if (col_q == LAST) col_q <= '0;
            else                    col_q <= col_q + 1'b1;
         end
      end
   endgenerate

   assign col_o = col_q;

   p_wr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      col_q <= LAST);
   p_wr_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (col_q == LAST) |=> (col_q == '0));
endmodule

// File: rtl/tpc_col_calc.sv
module tpc_col_calc #(
   parameter int RING    = 180,
   parameter int COLW    = 8,
   parameter int LAT_MAX = 160,
   parameter int LATW    = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [LATW-1:0] lat_cfg_i,
   input  logic            q_empty_i,
   input  logic [COLW-1:0] wr_col_i,
   output logic [COLW-1:0] trig_col_o
);
   localparam logic [LATW-1:0]  LAT_CAP  = LATW'(LAT_MAX);
   localparam logic [COLW:0]    RING_EXT = (COLW+1)'(RING);

   logic [LATW-1:0] lat_q;
   logic [LATW-1:0] lat_clamped;
   logic [COLW:0]   wr_ext, lat_ext, diff;

   assign lat_clamped = (lat_cfg_i > LAT_CAP) ? LAT_CAP : lat_cfg_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lat_q <= '0;
      else if (q_empty_i) lat_q <= lat_clamped;
   end

   always_comb begin
      wr_ext  = {1'b0, wr_col_i};
      lat_ext = (COLW+1)'(lat_q);
      if (wr_ext >= lat_ext) diff = wr_ext - lat_ext;
      else                   diff = wr_ext + RING_EXT - lat_ext;
   end

   assign trig_col_o = diff[COLW-1:0];

   p_lat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !q_empty_i |=> $stable(lat_q));
   p_lat_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lat_q <= LAT_CAP);
   p_col_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trig_col_o < COLW'(RING));
endmodule

// File: rtl/tpc_derand.sv
module tpc_derand #(
   parameter int DEPTH = 16,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] data_i,
   input  logic         pop_i,
   output logic         full_o,
   output logic         empty_o,
   output logic [W-1:0] head_o,
   output logic         drop_o
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);
   localparam logic [AW:0]   FULLC = (AW+1)'(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign full_o  = (cnt == FULLC);
   assign empty_o = (cnt == '0);
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && !empty_o;
   assign drop_o  = push_i && full_o;
   assign head_o  = mem[rp];

   generate
      if (tpc_pkg::is_pow2(DEPTH)) begin : g_wrap_free
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == LASTP) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == LASTP) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULLC);
   p_valid_after_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !full_o) |=> !empty_o);
   p_drop_keeps_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full_o && !pop_i) |=> full_o);
   p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/trig_pipe_ctrl.sv
module trig_pipe_ctrl #(
   parameter int LAT_MAX = 160,
   parameter int QDEPTH  = 16,
   parameter int GUARD   = 4,
   parameter int RING    = tpc_pkg::ring_size(LAT_MAX, QDEPTH, GUARD),
   parameter int COLW    = $clog2(RING),
   parameter int LATW    = $clog2(LAT_MAX + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trig_i,
   input  logic [LATW-1:0] lat_cfg_i,
   input  logic            rd_done_i,
   output logic [COLW-1:0] wr_col_o,
   output logic [COLW-1:0] rd_col_o,
   output logic            rd_valid_o,
   output logic            ovf_o
);
   generate
      if (RING <= LAT_MAX + QDEPTH) begin : g_bad_ring
         $error("ring must exceed maximum latency plus queue depth");
      end
      if (QDEPTH < 2) begin : g_bad_depth
         $error("queue depth must be at least 2");
      end
      if ((1 << COLW) < RING) begin : g_bad_colw
         $error("column width too small for ring");
      end
   endgenerate

   logic [COLW-1:0] wr_col, trig_col;
   logic            q_full, q_empty, q_drop;
   logic            ovf_q;

   tpc_wr_ring #(.RING(RING), .COLW(COLW)) u_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .col_o (wr_col)
   );

   tpc_col_calc #(.RING(RING), .COLW(COLW), .LAT_MAX(LAT_MAX), .LATW(LATW)) u_calc (
      .clk        (clk),
      .rst_n      (rst_n),
      .lat_cfg_i  (lat_cfg_i),
      .q_empty_i  (q_empty),
      .wr_col_i   (wr_col),
      .trig_col_o (trig_col)
   );

   tpc_derand #(.DEPTH(QDEPTH), .W(COLW)) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (trig_i),
      .data_i  (trig_col),
      .pop_i   (rd_done_i),
      .full_o  (q_full),
      .empty_o (q_empty),
      .head_o  (rd_col_o),
      .drop_o  (q_drop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ovf_q <= 1'b0;
      else if (q_drop) ovf_q <= 1'b1;
   end

   assign wr_col_o   = wr_col;
   assign rd_valid_o = !q_empty;
   assign ovf_o      = ovf_q;

   p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o);
   p_ovf_on_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && q_full) |=> ovf_o);
endmodule

// File: tb/trig_pipe_ctrl_tb.sv
module trig_pipe_ctrl_tb;
   localparam int RING = 180;
   localparam int LMAX = 160;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       trig = 1'b0;
   logic [7:0] lat_cfg = '0;
   logic       rd_done = 1'b0;
   logic [7:0] wr_col, rd_col;
   logic       rd_valid, ovf;

   int errors = 0;
   int checks = 0;
   bit ended = 0;
   int expq [64];
   int qh = 0, qt = 0;

   always #4 clk = ~clk;

   trig_pipe_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .lat_cfg_i(lat_cfg),
      .rd_done_i(rd_done), .wr_col_o(wr_col), .rd_col_o(rd_col),
      .rd_valid_o(rd_valid), .ovf_o(ovf)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int colof(input int w, input int l);
      int le = (l > LMAX) ? LMAX : l;
      return (w - le + RING) % RING;
   endfunction

   task automatic trig_one(input int l);
      trig = 1'b1;
      expq[qt % 64] = colof(int'(wr_col), l);
      qt++;
      @(negedge clk);
      trig = 1'b0;
   endtask

   task automatic pop_one(input string req);
      check({req, " valid"}, int'(rd_valid), 1);
      check({req, " column"}, int'(rd_col), expq[qh % 64]);
      qh++;
      rd_done = 1'b1;
      @(negedge clk);
      rd_done = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int prev;
      int wraps;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 wr_col", int'(wr_col), 0);
      check("R1 valid", int'(rd_valid), 0);
      check("R1 ovf", int'(ovf), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 first step", int'(wr_col), 1);

      // R2 ring stepping over more than two laps
      prev = int'(wr_col);
      wraps = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         check("R2 step", int'(wr_col), (prev + 1) % RING);
         if (int'(wr_col) == 0) wraps++;
         prev = int'(wr_col);
      end
      check("R2 wraps seen", wraps, 2);

      // R3 and R8: every latency value 0..175 (above 160 is clamped)
      for (int l = 0; l < 176; l++) begin
         lat_cfg = 8'(l);
         @(negedge clk);
         trig_one(l);
         pop_one(l > LMAX ? "R8" : "R3");
         check("R3 drained", int'(rd_valid), 0);
      end

      // R5 and R4: back-to-back triggers, popped in order
      lat_cfg = 8'd37;
      @(negedge clk);
      for (int i = 0; i < 5; i++) trig_one(37);
      check("R5 distinct", (expq[(qh + 1) % 64] - expq[qh % 64] + RING) % RING, 1);
      for (int i = 0; i < 5; i++) pop_one("R4 order");
      check("R4 empty after pops", int'(rd_valid), 0);

      // R4: completions while empty are ignored
      rd_done = 1'b1;
      repeat (3) @(negedge clk);
      rd_done = 1'b0;
      check("R4 empty stays", int'(rd_valid), 0);
      trig_one(37);
      pop_one("R4 after idle done");
      check("R4 single entry", int'(rd_valid), 0);

      // R7: latency change while queued is deferred
      lat_cfg = 8'd10;
      @(negedge clk);
      trig_one(10);
      lat_cfg = 8'd50;
      @(negedge clk);
      trig_one(10);
      pop_one("R7 first");
      pop_one("R7 held latency");
      @(negedge clk);
      trig_one(50);
      pop_one("R7 new latency");

      // R6: fill, overflow, sticky flag, contents intact
      lat_cfg = 8'd5;
      @(negedge clk);
      for (int i = 0; i < 16; i++) trig_one(5);
      check("R6 no ovf at full", int'(ovf), 0);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      check("R6 ovf set", int'(ovf), 1);
      for (int i = 0; i < 16; i++) pop_one("R6 contents");
      check("R6 empty", int'(rd_valid), 0);
      check("R6 ovf sticky", int'(ovf), 1);
      rst_n = 1'b0;
      @(negedge clk);
      check("R6 ovf reset", int'(ovf), 0);
      check("R1 valid after reset", int'(rd_valid), 0);

      if (!ended) begin
         ended = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule